// File: doc/BRIEF.md
# Sector-Tagged Test Stream Generator and Checker

This block sources a wide test data stream into a write FIFO and checks a stream of the same shape coming back from a read FIFO. Every beat is 512 bits (64 bytes), and eight beats make one 512-byte sector. A sector address counter starts at the value given with the start pulse and steps once per sector. The first beat of each sector carries that address as a 64-bit tag. The rest of the sector is filled from one of several payload patterns: a rising dword count, its inverse, constant zeros, constant ones, or a pseudo-random sequence produced by four independent 128-bit lanes.

The write side runs only after a one-cycle start pulse. It pauses while the FIFO reports almost-full and stops once the number of beats written equals the requested end size. The read side has no enable of its own. It pulls a beat whenever the read FIFO is not empty, rebuilds the expected beat with a second copy of the generator, and compares the two one cycle later. The first mismatch raises a sticky fail flag and freezes a snapshot of the failing byte address, the expected beat and the beat that was received. The start pulse also latches the start address, the end size and the pattern, and rewinds both sides.

Top module: `stpg_top`

## Requirements
- R1: The pattern code is latched at the start pulse: 3'b000 gives a rising count, 3'b001 a falling count, 3'b010 all zeros, 3'b011 all ones, and 3'b100 the pseudo-random lanes. Codes 3'b101 to 3'b111 behave like 3'b000. Beats of the two constant patterns carry no tag, so every bit of those beats is the constant.
- R2: A sector is 8 beats. For patterns other than the constants, bits [63:0] of the first beat of each sector (beat index b with b mod 8 = 0) hold the 48-bit sector address, zero-extended to 64 bits.
- R3: The sector address of beat b in a transfer equals the latched start address plus floor(b/8), computed in 48 bits.
- R4: For the rising count, dword d (bits [32d+31:32d], d = 0..15) of beat b holds (16*b + d) mod 2^32, except where R2 places the tag.
- R5: For the falling count, every dword is the bitwise inverse of the R4 value, except where R2 places the tag.
- R6: For the pseudo-random pattern, lane j (bits [128j+127:128j]) is seeded at each sector start with the low 32 bits of the sector address XOR a mask: 0x00000000, 0xFFFF0000, 0x0000FFFF and 0xFFFFFFFF for j = 0..3. One step maps s to {s[30:0], s[30]^s[20]^s[0]}. Word k (bits [32k+31:32k] of the lane) of in-sector beat i is the seed after 4i+k steps. R2 applies on top of this.
- R7: The write enable rises the cycle after the start pulse. It is high exactly when the write side is active, almost-full is low and fewer than end-size beats have been written. No write happens while almost-full is high, and writing stops after exactly end-size beats. An end size of 0 writes nothing.
- R8: The read enable equals the inverse of the read-empty input at all times, whether or not a start pulse has been seen, and is not limited by the end size. Read data is expected on the cycle after the enable.
- R9: Each side's byte count is 0 after reset and after a start pulse, and rises by 64 for each beat that side accepts. The count can be read while a transfer is running.
- R10: A compared beat that differs from the expected beat sets the fail flag. The flag stays set until the next start pulse, which clears it.
- R11: The first mismatch after reset or after a start pulse captures the byte address (sector address * 512 + (b mod 8) * 64), the expected beat and the received beat. Later mismatches leave this snapshot unchanged.
- R12: During and right after reset, the write enable is low, the fail flag is low and both byte counts are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_addr_i | input | 48 | Start sector address, in 512-byte units |
| end_beats_i | input | 32 | Number of beats to write |
| pattern_i | input | 3 | Payload pattern code |
| wr_start_i | input | 1 | One-cycle start pulse |
| wr_afull_i | input | 1 | Write FIFO almost full |
| wr_en_o | output | 1 | Write FIFO write enable |
| wr_data_o | output | 512 | Write FIFO data |
| rd_empty_i | input | 1 | Read FIFO empty |
| rd_en_o | output | 1 | Read FIFO read enable |
| rd_data_i | input | 512 | Read FIFO data, valid the cycle after the enable |
| fail_o | output | 1 | Sticky mismatch flag |
| wr_bytes_o | output | 38 | Bytes written since start |
| rd_bytes_o | output | 38 | Bytes read since start or reset |
| fail_byte_addr_o | output | 57 | Byte address of the first mismatch |
| fail_exp_o | output | 512 | Expected beat at the first mismatch |
| fail_got_o | output | 512 | Received beat at the first mismatch |

## Verification
The bench builds the block with its default parameters: 48-bit addresses, 32-bit beat counts and four lanes. With these values a 20-beat transfer covers two and a half sectors, so it exercises the tag on several sector starts, the mid-sector pseudo-random stepping and the reseeding at each new sector. All eight pattern codes are swept from two start addresses. One of these addresses makes the sector count carry out of the low 32 bits, which reaches the wide tag and the zero seed. The expected beats come from a bit-serial model in the bench. Reads are checked after reset without a start pulse, and again with two corrupted beats to check that the first-failure snapshot is kept.

// File: rtl/stpg_pkg.sv
package stpg_pkg;

  localparam int unsigned WORD_W       = 32;
  localparam int unsigned LANE_WORDS   = 4;
  localparam int unsigned LANE_W       = WORD_W * LANE_WORDS;
  localparam int unsigned SECTOR_BYTES = 512;

  typedef enum logic [2:0] {
    PAT_INC  = 3'b000,
    PAT_DEC  = 3'b001,
    PAT_ZERO = 3'b010,
    PAT_ONE  = 3'b011,
    PAT_PRBS = 3'b100
  } pat_e;

  // one step of the x^31 + x^21 + x + 1 sequence
  function automatic logic [WORD_W-1:0] prbs_step(input logic [WORD_W-1:0] s);
    prbs_step = {s[WORD_W-2:0], s[30] ^ s[20] ^ s[0]};
  endfunction

  // per-lane seed inversion so lanes never start alike
  function automatic logic [WORD_W-1:0] lane_mask(input int unsigned j);
    logic [1:0] sel;
    sel       = 2'(j);
    lane_mask = {{16{sel[0]}}, {16{sel[1]}}};
  endfunction

endpackage

// File: rtl/stpg_prbs_lanes.sv
module stpg_prbs_lanes
  import stpg_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    load_i,
  input  logic                    adv_i,
  input  logic [WORD_W-1:0]       seed_i,
  output logic [LANES*LANE_W-1:0] words_o
);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    logic [WORD_W-1:0] st_q, st_d;
    logic [WORD_W-1:0] wv [LANE_WORDS];

    // look-ahead chain: four words per clock
    always_comb begin
      wv[0] = st_q;
      for (int k = 1; k < LANE_WORDS; k++) begin
        wv[k] = prbs_step(wv[k-1]);
      end
    end

    always_comb begin
      st_d = st_q;
      if (load_i) begin
        st_d = seed_i ^ lane_mask(j);
      end else if (adv_i) begin
        st_d = prbs_step(wv[LANE_WORDS-1]);
      end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        st_q <= '0;
      end else begin
        st_q <= st_d;
      end
    end

    for (genvar k = 0; k < LANE_WORDS; k++) begin : g_word
      assign words_o[j*LANE_W + k*WORD_W +: WORD_W] = wv[k];
    end
  end

endmodule

// File: rtl/stpg_stream_ctx.sv
module stpg_stream_ctx
  import stpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    adv_i,
  input  logic [ADDR_W-1:0]       base_i,
  output logic [CNT_W-1:0]        cnt_o,
  output logic [ADDR_W-1:0]       sect_o,
  output logic [LANES*LANE_W-1:0] words_o
);

  localparam int unsigned BEAT_BYTES = LANES * LANE_W / 8;
  localparam int unsigned SECT_BEATS = SECTOR_BYTES / BEAT_BYTES;
  localparam int unsigned SB_W       = $clog2(SECT_BEATS);

  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] sect_q, sect_d, sect_inc;
  logic              last_beat;
  logic              lane_load;
  logic [WORD_W-1:0] lane_seed;

  assign last_beat = &cnt_q[SB_W-1:0];
  assign sect_inc  = sect_q + ADDR_W'(1);

  always_comb begin
    cnt_d  = cnt_q;
    sect_d = sect_q;
    if (clr_i) begin
      cnt_d  = '0;
      sect_d = base_i;
    end else if (adv_i) begin
      cnt_d = cnt_q + CNT_W'(1);
      if (last_beat) begin
        sect_d = sect_inc;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sect_q <= '0;
    end else begin
      cnt_q  <= cnt_d;
      sect_q <= sect_d;
    end
  end

  assign lane_load = clr_i | (adv_i & last_beat);
  assign lane_seed = clr_i ? base_i[WORD_W-1:0] : sect_inc[WORD_W-1:0];

  stpg_prbs_lanes #(
    .LANES (LANES)
  ) lanes_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (lane_load),
    .adv_i   (adv_i),
    .seed_i  (lane_seed),
    .words_o (words_o)
  );

  assign cnt_o  = cnt_q;
  assign sect_o = sect_q;

endmodule

// File: rtl/stpg_beat_fmt.sv
module stpg_beat_fmt
  import stpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic [2:0]              pat_i,
  input  logic [CNT_W-1:0]        cnt_i,
  input  logic [ADDR_W-1:0]       sect_i,
  input  logic [LANES*LANE_W-1:0] words_i,
  output logic [LANES*LANE_W-1:0] beat_o
);

  localparam int unsigned BEAT_W     = LANES * LANE_W;
  localparam int unsigned DW         = LANES * LANE_WORDS;
  localparam int unsigned DW_SH      = $clog2(DW);
  localparam int unsigned SECT_BEATS = SECTOR_BYTES / (BEAT_W / 8);
  localparam int unsigned SB_W       = $clog2(SECT_BEATS);

  logic [WORD_W-1:0] base_w;
  logic              head_beat;
  logic              const_pat;
  logic              unused_cnt_hi;

  assign base_w        = WORD_W'(cnt_i) << DW_SH;
  assign head_beat     = (cnt_i[SB_W-1:0] == '0);
  assign const_pat     = (pat_i == PAT_ZERO) || (pat_i == PAT_ONE);
  assign unused_cnt_hi = ^cnt_i;

  always_comb begin
    logic [WORD_W-1:0] inc_w;
    beat_o = '0;
    for (int d = 0; d < DW; d++) begin
      inc_w = base_w + WORD_W'(d);
      case (pat_i)
        PAT_DEC:  beat_o[d*WORD_W +: WORD_W] = ~inc_w;
        PAT_ZERO: beat_o[d*WORD_W +: WORD_W] = '0;
        PAT_ONE:  beat_o[d*WORD_W +: WORD_W] = '1;
        PAT_PRBS: beat_o[d*WORD_W +: WORD_W] = words_i[d*WORD_W +: WORD_W];
        default:  beat_o[d*WORD_W +: WORD_W] = inc_w;
      endcase
    end
    if (head_beat && !const_pat) begin
      beat_o[2*WORD_W-1:0] = (2*WORD_W)'(sect_i);
    end
  end

endmodule

// File: rtl/stpg_top.sv
module stpg_top
  import stpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LANES  = 4
) (
  input  logic                                   clk_i,
  input  logic                                   rst_ni,
  input  logic [ADDR_W-1:0]                      start_addr_i,
  input  logic [CNT_W-1:0]                       end_beats_i,
  input  logic [2:0]                             pattern_i,
  input  logic                                   wr_start_i,
  input  logic                                   wr_afull_i,
  output logic                                   wr_en_o,
  output logic [LANES*128-1:0]                   wr_data_o,
  input  logic                                   rd_empty_i,
  output logic                                   rd_en_o,
  input  logic [LANES*128-1:0]                   rd_data_i,
  output logic                                   fail_o,
  output logic [CNT_W+$clog2(LANES*16)-1:0]      wr_bytes_o,
  output logic [CNT_W+$clog2(LANES*16)-1:0]      rd_bytes_o,
  output logic [ADDR_W+$clog2(SECTOR_BYTES)-1:0] fail_byte_addr_o,
  output logic [LANES*128-1:0]                   fail_exp_o,
  output logic [LANES*128-1:0]                   fail_got_o
);

  localparam int unsigned BEAT_W     = LANES * LANE_W;
  localparam int unsigned BEAT_BYTES = BEAT_W / 8;
  localparam int unsigned BYTE_SH    = $clog2(BEAT_BYTES);
  localparam int unsigned SECT_BEATS = SECTOR_BYTES / BEAT_BYTES;
  localparam int unsigned SB_W       = $clog2(SECT_BEATS);
  localparam int unsigned FAIL_AW    = ADDR_W + $clog2(SECTOR_BYTES);

  // latched configuration
  logic [CNT_W-1:0]  end_q, end_d;
  logic [2:0]        pat_q, pat_d;
  logic              act_q, act_d;

  // per-side generator state
  logic [CNT_W-1:0]  wr_cnt, rd_cnt;
  logic [ADDR_W-1:0] wr_sect, rd_sect;
  logic [BEAT_W-1:0] wr_words, rd_words, rd_beat;

  // read compare pipeline and snapshot
  logic               vld_q, vld_d;
  logic [BEAT_W-1:0]  exp_q, exp_d;
  logic [FAIL_AW-1:0] paddr_q, paddr_d;
  logic               fail_q, fail_d;
  logic [FAIL_AW-1:0] faddr_q, faddr_d;
  logic [BEAT_W-1:0]  fexp_q, fexp_d;
  logic [BEAT_W-1:0]  fgot_q, fgot_d;
  logic               mismatch;
  logic               wr_done;

  assign wr_done = (wr_cnt == end_q);
  assign wr_en_o = act_q & ~wr_afull_i & ~wr_done;
  assign rd_en_o = ~rd_empty_i;

  stpg_stream_ctx #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES)
  ) wr_ctx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_start_i),
    .adv_i   (wr_en_o),
    .base_i  (start_addr_i),
    .cnt_o   (wr_cnt),
    .sect_o  (wr_sect),
    .words_o (wr_words)
  );

  stpg_stream_ctx #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES)
  ) rd_ctx_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (wr_start_i),
    .adv_i   (rd_en_o),
    .base_i  (start_addr_i),
    .cnt_o   (rd_cnt),
    .sect_o  (rd_sect),
    .words_o (rd_words)
  );

  stpg_beat_fmt #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES)
  ) wr_fmt_i (
    .pat_i   (pat_q),
    .cnt_i   (wr_cnt),
    .sect_i  (wr_sect),
    .words_i (wr_words),
    .beat_o  (wr_data_o)
  );

  stpg_beat_fmt #(
    .ADDR_W (ADDR_W),
    .CNT_W  (CNT_W),
    .LANES  (LANES)
  ) rd_fmt_i (
    .pat_i   (pat_q),
    .cnt_i   (rd_cnt),
    .sect_i  (rd_sect),
    .words_i (rd_words),
    .beat_o  (rd_beat)
  );

  assign mismatch = vld_q && (rd_data_i != exp_q);

  // next state
  always_comb begin
    end_d   = end_q;
    pat_d   = pat_q;
    act_d   = act_q;
    vld_d   = rd_en_o & ~wr_start_i;
    exp_d   = exp_q;
    paddr_d = paddr_q;
    fail_d  = fail_q;
    faddr_d = faddr_q;
    fexp_d  = fexp_q;
    fgot_d  = fgot_q;

    if (wr_start_i) begin
      end_d   = end_beats_i;
      pat_d   = pattern_i;
      act_d   = 1'b1;
      fail_d  = 1'b0;
      faddr_d = '0;
      fexp_d  = '0;
      fgot_d  = '0;
    end else begin
      if (act_q && wr_done) begin
        act_d = 1'b0;
      end
      if (rd_en_o) begin
        exp_d   = rd_beat;
        paddr_d = {rd_sect, rd_cnt[SB_W-1:0], {BYTE_SH{1'b0}}};
      end
      if (mismatch && !fail_q) begin
        fail_d  = 1'b1;
        faddr_d = paddr_q;
        fexp_d  = exp_q;
        fgot_d  = rd_data_i;
      end
    end
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      end_q   <= '0;
      pat_q   <= '0;
      act_q   <= 1'b0;
      vld_q   <= 1'b0;
      exp_q   <= '0;
      paddr_q <= '0;
      fail_q  <= 1'b0;
      faddr_q <= '0;
      fexp_q  <= '0;
      fgot_q  <= '0;
    end else begin
      end_q   <= end_d;
      pat_q   <= pat_d;
      act_q   <= act_d;
      vld_q   <= vld_d;
      exp_q   <= exp_d;
      paddr_q <= paddr_d;
      fail_q  <= fail_d;
      faddr_q <= faddr_d;
      fexp_q  <= fexp_d;
      fgot_q  <= fgot_d;
    end
  end

  assign fail_o           = fail_q;
  assign fail_byte_addr_o = faddr_q;
  assign fail_exp_o       = fexp_q;
  assign fail_got_o       = fgot_q;
  assign wr_bytes_o       = {wr_cnt, {BYTE_SH{1'b0}}};
  assign rd_bytes_o       = {rd_cnt, {BYTE_SH{1'b0}}};

endmodule

// File: rtl/stpg_top_chk.sv
module stpg_top_chk
  import stpg_pkg::*;
#(
  parameter int unsigned ADDR_W = 48,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned LANES  = 4
) (
  input logic                                   clk_i,
  input logic                                   rst_ni,
  input logic                                   wr_start_i,
  input logic                                   wr_en_o,
  input logic                                   rd_en_o,
  input logic                                   fail_o,
  input logic [CNT_W+$clog2(LANES*16)-1:0]      wr_bytes_o,
  input logic [CNT_W+$clog2(LANES*16)-1:0]      rd_bytes_o,
  input logic [ADDR_W+$clog2(SECTOR_BYTES)-1:0] fail_byte_addr_o,
  input logic [LANES*128-1:0]                   fail_exp_o,
  input logic [LANES*128-1:0]                   fail_got_o
);

  localparam int unsigned BPB = LANES * 16;
  localparam int unsigned BW  = CNT_W + $clog2(BPB);

  assert_wr_bytes_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_o && !wr_start_i) |=> (wr_bytes_o == $past(wr_bytes_o) + BW'(BPB)));

  assert_wr_bytes_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_o && !wr_start_i) |=> $stable(wr_bytes_o));

  assert_rd_bytes_step_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_o && !wr_start_i) |=> (rd_bytes_o == $past(rd_bytes_o) + BW'(BPB)));

  assert_start_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_start_i |=> (!fail_o && wr_bytes_o == '0 && rd_bytes_o == '0));

  assert_fail_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !wr_start_i) |=> fail_o);

  assert_fail_after_read_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_o) |-> $past(rd_en_o, 2));

  assert_snap_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && !wr_start_i) |=>
      ($stable(fail_exp_o) && $stable(fail_got_o) && $stable(fail_byte_addr_o)));

endmodule

bind stpg_top stpg_top_chk #(
  .ADDR_W (ADDR_W),
  .CNT_W  (CNT_W),
  .LANES  (LANES)
) chk_i (
  .clk_i            (clk_i),
  .rst_ni           (rst_ni),
  .wr_start_i       (wr_start_i),
  .wr_en_o          (wr_en_o),
  .rd_en_o          (rd_en_o),
  .fail_o           (fail_o),
  .wr_bytes_o       (wr_bytes_o),
  .rd_bytes_o       (rd_bytes_o),
  .fail_byte_addr_o (fail_byte_addr_o),
  .fail_exp_o       (fail_exp_o),
  .fail_got_o       (fail_got_o)
);

// File: tb/stpg_top_tb_top.sv
`timescale 1ns/1ps
module stpg_top_tb_top;

  logic         clk;
  logic         rst_ni;
  logic [47:0]  start_addr_i;
  logic [31:0]  end_beats_i;
  logic [2:0]   pattern_i;
  logic         wr_start_i;
  logic         wr_afull_i;
  logic         wr_en_o;
  logic [511:0] wr_data_o;
  logic         rd_empty_i;
  logic         rd_en_o;
  logic [511:0] rd_data_i;
  logic         fail_o;
  logic [37:0]  wr_bytes_o;
  logic [37:0]  rd_bytes_o;
  logic [56:0]  fail_byte_addr_o;
  logic [511:0] fail_exp_o;
  logic [511:0] fail_got_o;

  int n_chk  = 0;
  int n_fail = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  stpg_top dut_i (
    .clk_i            (clk),
    .rst_ni           (rst_ni),
    .start_addr_i     (start_addr_i),
    .end_beats_i      (end_beats_i),
    .pattern_i        (pattern_i),
    .wr_start_i       (wr_start_i),
    .wr_afull_i       (wr_afull_i),
    .wr_en_o          (wr_en_o),
    .wr_data_o        (wr_data_o),
    .rd_empty_i       (rd_empty_i),
    .rd_en_o          (rd_en_o),
    .rd_data_i        (rd_data_i),
    .fail_o           (fail_o),
    .wr_bytes_o       (wr_bytes_o),
    .rd_bytes_o       (rd_bytes_o),
    .fail_byte_addr_o (fail_byte_addr_o),
    .fail_exp_o       (fail_exp_o),
    .fail_got_o       (fail_got_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [511:0] act, input logic [511:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] step1(input logic [31:0] s);
    return {s[30:0], s[30] ^ s[20] ^ s[0]};
  endfunction

  function automatic logic [31:0] seed_mask(input int j);
    case (j)
      1:       return 32'hFFFF_0000;
      2:       return 32'h0000_FFFF;
      3:       return 32'hFFFF_FFFF;
      default: return 32'h0000_0000;
    endcase
  endfunction

  // expected beat b of a transfer
  function automatic logic [511:0] model(input int pat, input logic [47:0] base, input int b);
    logic [511:0] r;
    logic [47:0]  sect;
    logic [31:0]  w;
    int           ib;
    sect = base + 48'(b / 8);
    ib   = b % 8;
    if (pat == 2) return '0;
    if (pat == 3) return '1;
    for (int d = 0; d < 16; d++) begin
      if (pat == 4) begin
        w = sect[31:0] ^ seed_mask(d / 4);
        for (int s = 0; s < 4 * ib + (d % 4); s++) w = step1(w);
      end else begin
        w = 32'(b * 16 + d);
        if (pat == 1) w = ~w;
      end
      r[d*32 +: 32] = w;
    end
    if (ib == 0) r[63:0] = {16'h0, sect};
    return r;
  endfunction

  function automatic string pat_tag(input int pat);
    case (pat)
      1:       return "R5";
      2, 3:    return "R1";
      4:       return "R6";
      0:       return "R4";
      default: return "R1";
    endcase
  endfunction

  task automatic do_start(input int pat, input logic [47:0] addr, input int endb, input bit afull);
    @(negedge clk);
    pattern_i    = 3'(pat);
    start_addr_i = addr;
    end_beats_i  = 32'(endb);
    wr_afull_i   = afull;
    wr_start_i   = 1'b1;
    @(negedge clk);
    wr_start_i   = 1'b0;
  endtask

  task automatic run_write(input int pat, input logic [47:0] addr, input int n, input bit stall);
    int got = 0;
    int viol = 0;
    int cyc = 0;
    logic [511:0] e;
    do_start(pat, addr, n, 1'b0);
    while (got < n && cyc < 1000) begin
      wr_afull_i = stall && (cyc % 4 == 2);
      #1;
      if (wr_en_o) begin
        if (wr_afull_i) viol++;
        e = model(pat, addr, got);
        chk(wr_data_o === e, (got % 8 == 0 && pat != 2 && pat != 3) ? "R2" : pat_tag(pat),
            $sformatf("pat %0d beat %0d data", pat, got), wr_data_o, e);
        chk(wr_bytes_o == 38'(got * 64), "R9", "running write byte count",
            512'(wr_bytes_o), 512'(got * 64));
        got++;
      end
      @(negedge clk);
      cyc++;
    end
    wr_afull_i = 1'b0;
    #1;
    chk(viol == 0, "R7", "writes while almost full", 512'(viol), 0);
    chk(got == n, "R7", "beats written", 512'(got), 512'(n));
    chk(wr_en_o == 1'b0, "R7", "enable drops at end size", 512'(wr_en_o), 0);
    chk(wr_bytes_o == 38'(n * 64), "R9", "final write byte count", 512'(wr_bytes_o), 512'(n * 64));
    @(negedge clk);
  endtask

  task automatic run_read(input int pat, input logic [47:0] addr, input int n,
                          input int c1, input int c2);
    int  sent = 0;
    int  idx = 0;
    int  cyc = 0;
    int  bad_en = 0;
    bit  pend = 0;
    while ((sent < n || pend) && cyc < 1000) begin
      if (pend) begin
        rd_data_i = model(pat, addr, idx);
        if (idx == c1 || idx == c2) rd_data_i[(idx * 7) % 512] = ~rd_data_i[(idx * 7) % 512];
      end
      rd_empty_i = (sent >= n) || (cyc % 3 == 1);
      #1;
      if (rd_en_o !== !rd_empty_i) bad_en++;
      pend = rd_en_o;
      idx  = sent;
      if (rd_en_o) sent++;
      @(negedge clk);
      cyc++;
    end
    rd_empty_i = 1'b1;
    #1;
    chk(bad_en == 0, "R8", "read enable follows not-empty", 512'(bad_en), 0);
    chk(rd_bytes_o == 38'(n * 64), "R9", "read byte count", 512'(rd_bytes_o), 512'(n * 64));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 0, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [511:0] e;
    logic [511:0] g;
    rst_ni       = 1'b0;
    start_addr_i = '0;
    end_beats_i  = '0;
    pattern_i    = '0;
    wr_start_i   = 1'b0;
    wr_afull_i   = 1'b0;
    rd_empty_i   = 1'b1;
    rd_data_i    = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(wr_en_o == 1'b0, "R12", "write enable in reset", 512'(wr_en_o), 0);
    chk(fail_o == 1'b0, "R12", "fail in reset", 512'(fail_o), 0);
    chk(rd_en_o == 1'b0, "R12", "read enable with empty fifo", 512'(rd_en_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(wr_en_o == 1'b0 && wr_bytes_o == 0 && rd_bytes_o == 0, "R12", "state after reset",
        512'({wr_en_o, wr_bytes_o, rd_bytes_o}), 0);

    // R8: reads run without any start pulse, default rising count from address 0
    run_read(0, 48'h0, 20, -1, -1);
    chk(fail_o == 1'b0, "R8", "clean read after reset", 512'(fail_o), 0);

    // write sweep over all codes and two start addresses (R1..R7)
    for (int pat = 0; pat < 8; pat++) begin
      run_write(pat, 48'h0000_0000_0003, 20, pat[0]);
      run_write(pat, 48'h0000_FFFF_FFFE, 20, !pat[0]);
    end

    // R7: end size 0 writes nothing
    do_start(0, 48'h10, 0, 1'b0);
    begin
      int seen = 0;
      for (int i = 0; i < 6; i++) begin
        #1;
        if (wr_en_o) seen++;
        @(negedge clk);
      end
      chk(seen == 0, "R7", "no write with end size zero", 512'(seen), 0);
    end

    // clean reads after a start, several patterns (R3, R6, R8, R10)
    for (int p = 1; p < 5; p++) begin
      do_start(p, 48'h0000_0000_1234, 0, 1'b1);
      run_read(p, 48'h0000_0000_1234, 18, -1, -1);
      chk(fail_o == 1'b0, "R10", $sformatf("no fail on clean read pat %0d", p), 512'(fail_o), 0);
    end

    // R10/R11: two corrupted beats, first one is captured
    do_start(4, 48'h0000_0000_0777, 0, 1'b1);
    run_read(4, 48'h0000_0000_0777, 14, 5, 11);
    e = model(4, 48'h0000_0000_0777, 5);
    g = e;
    g[35] = ~g[35];
    chk(fail_o == 1'b1, "R10", "fail set on mismatch", 512'(fail_o), 1);
    chk(fail_byte_addr_o == 57'(48'h777 * 512 + 5 * 64), "R11", "first fail byte address",
        512'(fail_byte_addr_o), 512'(48'h777 * 512 + 5 * 64));
    chk(fail_exp_o === e, "R11", "first fail expected beat", fail_exp_o, e);
    chk(fail_got_o === g, "R11", "first fail received beat", fail_got_o, g);
    repeat (3) @(negedge clk);
    chk(fail_o == 1'b1, "R10", "fail stays set", 512'(fail_o), 1);

    // start clears the flag and counts (R9, R10)
    do_start(0, 48'h0, 0, 1'b1);
    #1;
    chk(fail_o == 1'b0, "R10", "start clears fail", 512'(fail_o), 0);
    chk(rd_bytes_o == 0 && wr_bytes_o == 0, "R9", "start clears counts",
        512'({wr_bytes_o, rd_bytes_o}), 0);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule